// File: doc/BRIEF.md
# Gray-Scale Pulse-Width Channel Driver

This block turns a 4-bit gray level held for each of 64 channels into a timed switch-enable window. An external step clock advances a shared 4-bit step counter. An active-low load input holds that counter at zero, and while load is low each channel takes a new level. After load is released, every channel opens its window on the first falling step-clock edge. It then keeps the window open for as many step-clock periods as its level value. The counter stops at its top value, so the window fires only once per print cycle.

Two sets of strobe inputs gate every window by phase. A three-phase set picks channels by index modulo three, and a two-phase set picks odd or even channels. A channel is driven only when its window is open and both of its strobes are high. For each channel the block also gives a 2-bit rail code. The code tells the analog stage which of the two scan rails of that channel's pair group the switch pair connects to. Level shifters, transmission gates and the serial loading path are outside this block. Levels arrive as one flat parallel bus.

The step clock and load input are asynchronous to `clk` and are synchronised inside the block. Strobes are used as they arrive.

Top module: `gs_pulse_driver`

## Requirements
- R1: Channel i (0-based) takes its level from `lvl_in[4*i+3:4*i]`, with bit 4*i as the least significant bit. All 16 values from 0 to 15 are accepted.
- R2: While `load_n` is low, the step counter is held at zero and every `out_en` bit is 0. The rail codes then show every channel as off.
- R3: After `load_n` rises, a channel at level N (N > 0) turns on with the first falling edge of `step_clk`. It stays on for exactly N step-clock periods. The output changes by the fourth `clk` rising edge after each `step_clk` falling edge. A channel at level 0 never turns on.
- R4: The step counter stops at 15 and does not wrap. Once a window has closed, it stays closed until `load_n` goes low and high again, however many further step edges arrive.
- R5: Channel i is enabled only while `stb_tri[i mod 3]` is high.
- R6: Channel i is enabled only while `stb_duo[i mod 2]` is high. `stb_duo[0]` covers even indices (channels 1, 3, 5, ... counted from 1), and `stb_duo[1]` covers odd indices.
- R7: `rail_code[2*i+1:2*i]` gives the rail for channel i. Bit 1 is `(i >> 1) & 1`: 0 means pair group A/B and 1 means pair group C/D. Bit 0 is 0 while the channel is on (rail A or C) and 1 while it is off (rail B or D).
- R8: Changes on `lvl_in` while `load_n` is high have no effect on any window.
- R9: After a synchronous reset (`rst_n` low on a `clk` edge), every `out_en` bit is 0 and every rail code shows off.
- R10: Pulling `load_n` low during an open window closes it. The next release restarts the windows from the newly loaded levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_clk | input | 1 | External gray-step clock, asynchronous to clk |
| load_n | input | 1 | Active-low counter clear and level capture |
| lvl_in | input | 256 | Per-channel 4-bit levels, channel i at bits 4i+3..4i |
| stb_tri | input | 3 | Three-phase strobes, bit k gates channels with i mod 3 = k |
| stb_duo | input | 2 | Two-phase strobes, bit k gates channels with i mod 2 = k |
| out_en | output | 64 | Per-channel switch enable |
| rail_code | output | 128 | Per-channel rail code: 00 A, 01 B, 10 C, 11 D |

## Verification
The assertions check the following on every cycle:
- the counter clears while load is held low,
- the counter only ever steps by one,
- the counter stays at its top value once it gets there,
- captured levels stay frozen during a release,
- an enable never appears for a level-0 channel or without both of its strobes,
- every output is dark after two cycles of held load.

Only the bench scenarios can show that a window lasts exactly N step periods and starts on the first falling edge. The same holds for the exact rail code of each channel under mixed strobe patterns, for levels changed after release being ignored, and for an aborted window restarting from fresh levels.

// File: rtl/gs_pkg.sv
// Shared definitions for the gray-scale pulse-width driver.
// Assumes: levels are 4 bits wide unless a user overrides the top parameter.
package gs_pkg;

    // Default level width in bits (16 gray steps).
    localparam int GS_LVL_W = 4;

    // Step timer states: counter held, released but waiting for first
    // falling step edge, and counting.
    typedef enum logic [1:0] {
        TS_HOLD = 2'd0,
        TS_WAIT = 2'd1,
        TS_RUN  = 2'd2
    } tstate_e;

endpackage

// File: rtl/gs_step_timer.sv
// Step timer: brings step_clk and load_n into the clk domain, detects
// falling step edges and runs a saturating step counter.
// Assumes: step_clk and load_n are slow compared with clk (several clk
// cycles per level), so a two-flop chain is enough. Both go through the
// same number of stages, so their relative timing is kept.
module gs_step_timer
    import gs_pkg::*;
#(
    parameter int CW    = GS_LVL_W,
    parameter int SYNC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_clk,
    input  logic          load_n,
    output logic [CW-1:0] cnt,
    output logic          run,
    output logic          hold
);

    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [SYNC-1:0] stp_sr;
    logic [SYNC-1:0] ld_sr;
    logic            stp_prev;
    logic            fall;
    logic            ld_hi;
    tstate_e         st;

    // Synchronise step clock and load, and keep the last step level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stp_sr   <= {SYNC{1'b1}};
            ld_sr    <= '0;
            stp_prev <= 1'b1;
        end else begin
            stp_sr   <= {stp_sr[SYNC-2:0], step_clk};
            ld_sr    <= {ld_sr[SYNC-2:0], load_n};
            stp_prev <= stp_sr[SYNC-1];
        end
    end

    assign fall  = stp_prev & ~stp_sr[SYNC-1];
    assign ld_hi = ld_sr[SYNC-1];

    // Counter state: clear while load is low, arm on release, count falling edges up to the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= TS_HOLD;
            cnt <= '0;
        end else if (!ld_hi) begin
            st  <= TS_HOLD;
            cnt <= '0;
        end else begin
            case (st)
                TS_HOLD: st <= TS_WAIT;
                TS_WAIT: begin
                    if (fall) begin
                        st  <= TS_RUN;
                        cnt <= '0;
                    end
                end
                TS_RUN: begin
                    if (fall && (cnt != CMAX)) cnt <= cnt + 1'b1;
                end
                default: st <= TS_HOLD;
            endcase
        end
    end

    assign run  = (st == TS_RUN);
    assign hold = ~ld_hi;

    AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0) && !run); // R2

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (cnt == CMAX) && ld_hi) |=> (cnt == CMAX)); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt != $past(cnt)) && (cnt != '0)) |-> (cnt == $past(cnt) + 1'b1)); // R3

endmodule

// File: rtl/gs_level_window.sv
// Level capture and window compare: each channel takes its level while
// the timer holds, and opens its window while the running count is
// below that level.
// Assumes: hold and run come from gs_step_timer in the same clk domain.
module gs_level_window #(
    parameter int NCH = 64,
    parameter int LW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              run,
    input  logic [LW-1:0]     cnt,
    input  logic [NCH*LW-1:0] lvl_in,
    output logic [NCH*LW-1:0] lvl_q,
    output logic [NCH-1:0]    win
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Capture this channel's level only while the counter is held.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q[i*LW +: LW] <= '0;
            end else if (hold) begin
                lvl_q[i*LW +: LW] <= lvl_in[i*LW +: LW];
            end
        end

        // Window is open while counting and the count is still below the level.
        always_comb begin
            win[i] = run && (cnt < lvl_q[i*LW +: LW]);
        end
    end

    AST_LVL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !$past(hold)) |-> $stable(lvl_q)); // R8

endmodule

// File: rtl/gs_phase_gate.sv
// Phase gate: registers each channel's window ANDed with its three-phase
// strobe (index mod 3) and its two-phase strobe (index mod 2).
// Assumes: strobes are quasi-static relative to clk; they are not
// synchronised here.
module gs_phase_gate #(
    parameter int NCH  = 64,
    parameter int NTRI = 3,
    parameter int NDUO = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  win,
    input  logic [NTRI-1:0] stb_tri,
    input  logic [NDUO-1:0] stb_duo,
    output logic [NCH-1:0]  out_en
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int TI = i % NTRI;
        localparam int DI = i % NDUO;

        // Register the gated enable for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) out_en[i] <= 1'b0;
            else        out_en[i] <= win[i] & stb_tri[TI] & stb_duo[DI];
        end

        AST_GATE_TRI: assert property (@(posedge clk) disable iff (!rst_n)
            out_en[i] |-> $past(stb_tri[TI])); // R5

        AST_GATE_DUO: assert property (@(posedge clk) disable iff (!rst_n)
            out_en[i] |-> $past(stb_duo[DI])); // R6
    end

endmodule

// File: rtl/gs_pulse_driver.sv
// Gray-scale pulse-width driver top: step timer, per-channel level
// window, phase gating and rail code for each channel.
// Assumes: lvl_in is stable while load_n is low; step_clk and load_n are
// slow compared with clk.
module gs_pulse_driver
    import gs_pkg::*;
#(
    parameter int NCH  = 64,
    parameter int LW   = GS_LVL_W,
    parameter int SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_clk,
    input  logic              load_n,
    input  logic [NCH*LW-1:0] lvl_in,
    input  logic [2:0]        stb_tri,
    input  logic [1:0]        stb_duo,
    output logic [NCH-1:0]    out_en,
    output logic [2*NCH-1:0]  rail_code
);

    logic [LW-1:0]     cnt;
    logic              run;
    logic              hold;
    logic [NCH*LW-1:0] lvl_q;
    logic [NCH-1:0]    win;

    gs_step_timer #(.CW(LW), .SYNC(SYNC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_clk (step_clk),
        .load_n   (load_n),
        .cnt      (cnt),
        .run      (run),
        .hold     (hold)
    );

    gs_level_window #(.NCH(NCH), .LW(LW)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (hold),
        .run    (run),
        .cnt    (cnt),
        .lvl_in (lvl_in),
        .lvl_q  (lvl_q),
        .win    (win)
    );

    gs_phase_gate #(.NCH(NCH), .NTRI(3), .NDUO(2)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .win     (win),
        .stb_tri (stb_tri),
        .stb_duo (stb_duo),
        .out_en  (out_en)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_rail
        localparam logic GRP = 1'(i >> 1);

        // Rail code: pair group in bit 1, off-rail choice in bit 0.
        always_comb begin
            rail_code[2*i+1] = GRP;
            rail_code[2*i]   = ~out_en[i];
        end

        AST_ZERO_DARK: assert property (@(posedge clk) disable iff (!rst_n)
            out_en[i] |-> ($past(lvl_q[i*LW +: LW]) != '0)); // R3
    end

    AST_HOLD_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) |=> (out_en == '0)); // R2

endmodule

// File: tb/sim_gs_pulse_driver.sv
// Self-checking bench for gs_pulse_driver.
module sim_gs_pulse_driver;

    localparam int TCLK = 10;
    localparam int NCH  = 64;
    localparam int LW   = 4;

    typedef struct packed {
        logic [3:0] mul;
        logic [3:0] add;
        logic [2:0] tri_s;
        logic [1:0] duo_s;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{mul: 4'd1,  add: 4'd0,  tri_s: 3'b111, duo_s: 2'b11},
        '{mul: 4'd3,  add: 4'd5,  tri_s: 3'b111, duo_s: 2'b11},
        '{mul: 4'd7,  add: 4'd2,  tri_s: 3'b001, duo_s: 2'b11},
        '{mul: 4'd5,  add: 4'd9,  tri_s: 3'b110, duo_s: 2'b10},
        '{mul: 4'd11, add: 4'd15, tri_s: 3'b010, duo_s: 2'b01},
        '{mul: 4'd0,  add: 4'd0,  tri_s: 3'b111, duo_s: 2'b11}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              step_clk = 1'b1;
    logic              load_n = 1'b0;
    logic [NCH*LW-1:0] lvl_in = '0;
    logic [2:0]        stb_tri = '0;
    logic [1:0]        stb_duo = '0;
    logic [NCH-1:0]    out_en;
    logic [2*NCH-1:0]  rail_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(TCLK/2) clk = ~clk;

    gs_pulse_driver u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_clk  (step_clk),
        .load_n    (load_n),
        .lvl_in    (lvl_in),
        .stb_tri   (stb_tri),
        .stb_duo   (stb_duo),
        .out_en    (out_en),
        .rail_code (rail_code)
    );

    function automatic logic [3:0] lvl_of(int i, logic [3:0] mul, logic [3:0] add);
        int v = (i * int'(mul) + int'(add)) % 16;
        return v[3:0];
    endfunction

    function automatic logic [NCH-1:0] exp_en(int k, logic [3:0] mul, logic [3:0] add,
                                              logic [2:0] t, logic [1:0] d);
        logic [NCH-1:0] r = '0;
        for (int i = 0; i < NCH; i++)
            r[i] = (k >= 1) && (k <= int'(lvl_of(i, mul, add))) && t[i % 3] && d[i % 2];
        return r;
    endfunction

    function automatic logic [2*NCH-1:0] exp_rail(logic [NCH-1:0] en);
        logic [2*NCH-1:0] r;
        for (int i = 0; i < NCH; i++) begin
            r[2*i+1] = ((i >> 1) & 1) != 0;
            r[2*i]   = ~en[i];
        end
        return r;
    endfunction

    task automatic check(string req, string what, logic [2*NCH-1:0] act, logic [2*NCH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One step period: falling edge, rising edge at 8 clk, sample at 12 clk.
    task automatic do_step(string req, logic [NCH-1:0] exp);
        step_clk = 1'b0;
        repeat (8) @(negedge clk);
        step_clk = 1'b1;
        repeat (4) @(negedge clk);
        check(req, "out_en", {{NCH{1'b0}}, out_en}, {{NCH{1'b0}}, exp});
        check("R7", "rail_code", rail_code, exp_rail(exp));
        repeat (4) @(negedge clk);
    endtask

    // Full print cycle: load, hold two steps, release, then nsteps.
    task automatic run_print(string req, logic [3:0] mul, logic [3:0] add,
                             logic [2:0] t, logic [1:0] d, int nsteps, bit scramble);
        stb_tri = t;
        stb_duo = d;
        load_n  = 1'b0;
        for (int i = 0; i < NCH; i++) lvl_in[i*LW +: LW] = lvl_of(i, mul, add);
        do_step("R2", '0);
        do_step("R2", '0);
        load_n = 1'b1;
        repeat (4) @(negedge clk);
        if (scramble) lvl_in = ~lvl_in;
        repeat (4) @(negedge clk);
        for (int k = 1; k <= nsteps; k++) do_step(req, exp_en(k, mul, add, t, d));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        check("R9", "out_en", {{NCH{1'b0}}, out_en}, '0);
        check("R9", "rail_code", rail_code, exp_rail('0));
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Table walk: R1 level bit order, R3 widths, R5/R6 strobe gating
        for (int v = 0; v < NVEC; v++)
            run_print("R3", VECS[v].mul, VECS[v].add, VECS[v].tri_s, VECS[v].duo_s, 17, 1'b0);

        // R1: single-bit levels, MSB only then LSB only
        run_print("R1", 4'd0, 4'd8, 3'b111, 2'b11, 10, 1'b0);
        run_print("R1", 4'd0, 4'd1, 3'b111, 2'b11, 3, 1'b0);

        // R5: one three-phase strobe at a time
        run_print("R5", 4'd1, 4'd3, 3'b100, 2'b11, 6, 1'b0);
        // R6: only the odd-index two-phase strobe
        run_print("R6", 4'd1, 4'd3, 3'b111, 2'b10, 6, 1'b0);

        // R4: full level, run well past saturation
        run_print("R4", 4'd0, 4'd15, 3'b111, 2'b11, 24, 1'b0);

        // R8: level bus inverted after release is ignored
        run_print("R8", 4'd3, 4'd1, 3'b111, 2'b11, 17, 1'b1);

        // R10: abort an open window, then reload smaller levels
        run_print("R10", 4'd0, 4'd15, 3'b111, 2'b11, 5, 1'b0);
        run_print("R10", 4'd0, 4'd3, 3'b111, 2'b11, 6, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule